// File: doc/BRIEF.md
# Dual-Port Diagnostic Status Memory

This block holds a 64-byte status image that system software keeps up to date and that two outside parties can inspect. Software updates single bytes through a write strobe that is always taken and never stalls. An independent monitoring host reaches the image through its own command port. There it can read a run of consecutive bytes or zero a run of bytes, and the hardware carries out both with no help from software. A second, read-only path serves the primary host. It returns the same contents, and it rejects any attempt to clear them.

Both command ports take byte-level commands that a serial front end has already decoded. Each command carries an operation, a start offset and a length. A command is accepted on a cycle where `*_cmd_valid` and `*_cmd_ready` are both high. `*_cmd_ready` stays low while a read reply is still streaming. Read data leaves as a valid/ready stream. The data and last flag hold steady while the receiver holds ready low, and the next beat moves only on a cycle where valid and ready are both high. Every requested byte is copied into a reply buffer on the cycle the command is accepted, so a multi-byte field cannot tear. The block also fixes the framing of the monitor port. It samples the host-interface select pin during reset and reports the opposite choice.

Top module: `diag_status_mem`

## Requirements
- R1: After reset all 64 bytes read as 0x00, both command ports are ready, no read stream is valid, and neither error pin is high.
- R2: A software write (`sw_wr_en` high) stores `sw_wr_data` at `sw_wr_addr` on that clock edge, and any later read returns it.
- R3: A monitor read (op 0) of length L from offset O returns bytes O to O+L-1 in ascending order, one per handshake, with `mon_rd_last` high only on the final beat. While `mon_rd_ready` is low, `mon_rd_valid`, `mon_rd_data` and `mon_rd_last` hold.
- R4: Read data is the memory content on the cycle the read command is accepted. Writes or clears made after acceptance do not appear in that reply.
- R5: A monitor clear (op 1) sets bytes O to O+L-1 to 0x00 on the acceptance edge. Other bytes are untouched and no read stream follows.
- R6: When a software write and a monitor clear hit the same byte on the same edge, the byte takes the written value.
- R7: A command with L = 0 or O+L > 64 is rejected whole. The port's error pin is high for exactly the one cycle after acceptance, no byte changes, and no read stream starts.
- R8: The host path reads exactly like R3/R4. A host clear (op 1) alters no byte, starts no stream, and raises `host_err` for the one cycle after acceptance.
- R9: `mon_use_spi` equals the inverse of `host_sel_spi` as sampled on the last clock edge of reset. Later changes of the pin have no effect.
- R10: A port's `*_cmd_ready` is low from the acceptance of a valid read until its last beat has been taken, and high again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_spi | input | 1 | Host interface select: 1 means host uses SPI, sampled during reset |
| mon_use_spi | output | 1 | 1: monitor port framed as SPI, 0: as I2C |
| sw_wr_en | input | 1 | Software byte write strobe |
| sw_wr_addr | input | 6 | Software write byte address |
| sw_wr_data | input | 8 | Software write data |
| mon_cmd_valid | input | 1 | Monitor command valid |
| mon_cmd_ready | output | 1 | Monitor command ready |
| mon_cmd_op | input | 1 | 0 read, 1 clear |
| mon_cmd_off | input | 6 | Start offset |
| mon_cmd_len | input | 7 | Byte count (1 to 64 valid) |
| mon_rd_valid | output | 1 | Monitor read beat valid |
| mon_rd_ready | input | 1 | Monitor read beat ready |
| mon_rd_data | output | 8 | Monitor read byte |
| mon_rd_last | output | 1 | Final beat of the reply |
| mon_err | output | 1 | One-cycle pulse after a rejected monitor command |
| host_cmd_valid | input | 1 | Host command valid |
| host_cmd_ready | output | 1 | Host command ready |
| host_cmd_op | input | 1 | 0 read, 1 clear (always rejected) |
| host_cmd_off | input | 6 | Start offset |
| host_cmd_len | input | 7 | Byte count |
| host_rd_valid | output | 1 | Host read beat valid |
| host_rd_ready | input | 1 | Host read beat ready |
| host_rd_data | output | 8 | Host read byte |
| host_rd_last | output | 1 | Final beat of the reply |
| host_err | output | 1 | One-cycle pulse after a rejected host command |

## Verification
The hardest cases to reach are the ones that need two events in one cycle. One is a monitor clear that lands on the same edge as a software write to a byte inside the cleared range. Another is a host read accepted on the same edge as a monitor clear of overlapping bytes. A third is a stalled reply while software rewrites the very bytes being returned. The bench drives all of these from one task, which places any mix of the three input groups on the same clock edge. It holds the read-ready inputs low, or toggles them at random, to stretch replies across later writes. A randomized phase then mixes offsets and lengths that straddle the 64-byte limit with concurrent writes.

// File: rtl/diag_pkg.sv
package diag_pkg;
  localparam int DIAG_DEPTH = 64;
  localparam int DIAG_DW    = 8;

  typedef enum logic {
    DIAG_OP_READ  = 1'b0,
    DIAG_OP_CLEAR = 1'b1
  } diag_op_e;
endpackage

// File: rtl/diag_proto_latch.sv
module diag_proto_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic host_sel_spi,
  output logic mon_use_spi
);
  logic host_spi_q;

  // Follows the pin while reset is held; frozen once reset is released.
  always_ff @(posedge clk) begin
    if (!rst_n) host_spi_q <= host_sel_spi;
  end

  assign mon_use_spi = ~host_spi_q;
endmodule

// File: rtl/diag_store.sv
module diag_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic                       clr_en,
  input  logic [AW-1:0]              clr_off,
  input  logic [LW-1:0]              clr_len,
  output logic [DEPTH-1:0][DW-1:0]   mem
);
  logic [LW:0] clr_lo;
  logic [LW:0] clr_hi;

  assign clr_lo = {2'b00, clr_off};
  assign clr_hi = clr_lo + {1'b0, clr_len};

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    localparam logic [LW:0] IDX = (LW+1)'(i);
    logic hit_wr;
    logic hit_clr;

    assign hit_wr  = wr_en && (wr_addr == AW'(i));
    assign hit_clr = clr_en && (IDX >= clr_lo) && (IDX < clr_hi);

    // Software write has priority so a live update is never lost.
    always_ff @(posedge clk) begin
      if (!rst_n)       mem[i] <= '0;
      else if (hit_wr)  mem[i] <= wr_data;
      else if (hit_clr) mem[i] <= '0;
    end
  end
endmodule

// File: rtl/diag_reader.sv
module diag_reader #(
  parameter int DEPTH       = 64,
  parameter int DW          = 8,
  parameter bit ALLOW_CLEAR = 1'b1,
  localparam int AW         = $clog2(DEPTH),
  localparam int LW         = AW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_op,
  input  logic [AW-1:0]             cmd_off,
  input  logic [LW-1:0]             cmd_len,
  input  logic [DEPTH-1:0][DW-1:0]  mem,
  output logic                      rd_valid,
  input  logic                      rd_ready,
  output logic [DW-1:0]             rd_data,
  output logic                      rd_last,
  output logic                      err,
  output logic                      clr_en,
  output logic [AW-1:0]             clr_off,
  output logic [LW-1:0]             clr_len
);
  import diag_pkg::*;

  logic                     busy;
  logic [AW-1:0]            ptr;
  logic [LW-1:0]            remain;
  logic [DEPTH-1:0][DW-1:0] snap;

  logic [LW:0] span_end;
  logic        range_bad;
  logic        accept;
  logic        is_clear;
  logic        reject;
  logic        start_rd;
  logic        beat;

  assign span_end  = {2'b00, cmd_off} + {1'b0, cmd_len};
  assign range_bad = (cmd_len == '0) || (span_end > (LW+1)'(DEPTH));
  assign accept    = cmd_valid && !busy;
  assign is_clear  = (diag_op_e'(cmd_op) == DIAG_OP_CLEAR);
  assign reject    = accept && (range_bad || (is_clear && !ALLOW_CLEAR));
  assign start_rd  = accept && !is_clear && !range_bad;
  assign beat      = busy && rd_ready;

  assign clr_en  = accept && is_clear && !range_bad && ALLOW_CLEAR;
  assign clr_off = cmd_off;
  assign clr_len = cmd_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ptr    <= '0;
      remain <= '0;
      snap   <= '0;
      err    <= 1'b0;
    end else begin
      err <= reject;
      if (start_rd) begin
        snap   <= mem;
        ptr    <= cmd_off;
        remain <= cmd_len;
        busy   <= 1'b1;
      end else if (beat) begin
        ptr    <= ptr + 1'b1;
        remain <= remain - 1'b1;
        if (remain == LW'(1)) busy <= 1'b0;
      end
    end
  end

  assign cmd_ready = !busy;
  assign rd_valid  = busy;
  assign rd_data   = snap[ptr];
  assign rd_last   = busy && (remain == LW'(1));
endmodule

// File: rtl/diag_status_mem.sv
module diag_status_mem #(
  parameter int DEPTH = diag_pkg::DIAG_DEPTH,
  parameter int DW    = diag_pkg::DIAG_DW,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_spi,
  output logic          mon_use_spi,
  input  logic          sw_wr_en,
  input  logic [AW-1:0] sw_wr_addr,
  input  logic [DW-1:0] sw_wr_data,
  input  logic          mon_cmd_valid,
  output logic          mon_cmd_ready,
  input  logic          mon_cmd_op,
  input  logic [AW-1:0] mon_cmd_off,
  input  logic [LW-1:0] mon_cmd_len,
  output logic          mon_rd_valid,
  input  logic          mon_rd_ready,
  output logic [DW-1:0] mon_rd_data,
  output logic          mon_rd_last,
  output logic          mon_err,
  input  logic          host_cmd_valid,
  output logic          host_cmd_ready,
  input  logic          host_cmd_op,
  input  logic [AW-1:0] host_cmd_off,
  input  logic [LW-1:0] host_cmd_len,
  output logic          host_rd_valid,
  input  logic          host_rd_ready,
  output logic [DW-1:0] host_rd_data,
  output logic          host_rd_last,
  output logic          host_err
);
  logic [DEPTH-1:0][DW-1:0] mem;

  logic          m_clr_en,  h_clr_en;
  logic [AW-1:0] m_clr_off, h_clr_off;
  logic [LW-1:0] m_clr_len, h_clr_len;
  logic          clr_en;
  logic [AW-1:0] clr_off;
  logic [LW-1:0] clr_len;

  // The host reader is built without clear rights; its request stays low.
  assign clr_en  = m_clr_en | h_clr_en;
  assign clr_off = m_clr_en ? m_clr_off : h_clr_off;
  assign clr_len = m_clr_en ? m_clr_len : h_clr_len;

  diag_proto_latch u_proto (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel_spi (host_sel_spi),
    .mon_use_spi  (mon_use_spi)
  );

  diag_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sw_wr_en),
    .wr_addr (sw_wr_addr),
    .wr_data (sw_wr_data),
    .clr_en  (clr_en),
    .clr_off (clr_off),
    .clr_len (clr_len),
    .mem     (mem)
  );

  diag_reader #(.DEPTH(DEPTH), .DW(DW), .ALLOW_CLEAR(1'b1)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (mon_cmd_valid),
    .cmd_ready (mon_cmd_ready),
    .cmd_op    (mon_cmd_op),
    .cmd_off   (mon_cmd_off),
    .cmd_len   (mon_cmd_len),
    .mem       (mem),
    .rd_valid  (mon_rd_valid),
    .rd_ready  (mon_rd_ready),
    .rd_data   (mon_rd_data),
    .rd_last   (mon_rd_last),
    .err       (mon_err),
    .clr_en    (m_clr_en),
    .clr_off   (m_clr_off),
    .clr_len   (m_clr_len)
  );

  diag_reader #(.DEPTH(DEPTH), .DW(DW), .ALLOW_CLEAR(1'b0)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (host_cmd_valid),
    .cmd_ready (host_cmd_ready),
    .cmd_op    (host_cmd_op),
    .cmd_off   (host_cmd_off),
    .cmd_len   (host_cmd_len),
    .mem       (mem),
    .rd_valid  (host_rd_valid),
    .rd_ready  (host_rd_ready),
    .rd_data   (host_rd_data),
    .rd_last   (host_rd_last),
    .err       (host_err),
    .clr_en    (h_clr_en),
    .clr_off   (h_clr_off),
    .clr_len   (h_clr_len)
  );
endmodule

// File: rtl/diag_status_mem_chk.sv
module diag_status_mem_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mon_use_spi,
  input logic          mon_cmd_valid,
  input logic          mon_cmd_ready,
  input logic          mon_rd_valid,
  input logic          mon_rd_ready,
  input logic [DW-1:0] mon_rd_data,
  input logic          mon_rd_last,
  input logic          mon_err,
  input logic          host_cmd_valid,
  input logic          host_cmd_ready,
  input logic          host_cmd_op,
  input logic          host_rd_valid,
  input logic          host_rd_ready,
  input logic [DW-1:0] host_rd_data,
  input logic          host_rd_last,
  input logic          host_err
);
  assert_mon_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_rd_valid && !mon_rd_ready) |=>
      (mon_rd_valid && $stable(mon_rd_data) && $stable(mon_rd_last)));

  assert_host_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_valid && !host_rd_ready) |=>
      (host_rd_valid && $stable(host_rd_data) && $stable(host_rd_last)));

  assert_last_in_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mon_rd_last |-> mon_rd_valid);

  assert_busy_blocks_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_cmd_valid && mon_rd_valid) |-> !mon_cmd_ready);

  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mon_err |-> !mon_rd_valid);

  assert_host_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cmd_valid && host_cmd_ready && host_cmd_op) |=> (host_err && !host_rd_valid));

  assert_proto_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mon_use_spi));
endmodule

bind diag_status_mem diag_status_mem_chk #(.DW(DW)) u_chk (.*);

// File: tb/diag_status_mem_tb.sv
module diag_status_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel_spi = 1'b0;
  logic mon_use_spi;
  logic sw_wr_en = 1'b0;
  logic [5:0] sw_wr_addr = '0;
  logic [7:0] sw_wr_data = '0;
  logic mon_cmd_valid = 1'b0, mon_cmd_ready, mon_cmd_op = 1'b0;
  logic [5:0] mon_cmd_off = '0;
  logic [6:0] mon_cmd_len = '0;
  logic mon_rd_valid, mon_rd_ready, mon_rd_last, mon_err;
  logic [7:0] mon_rd_data;
  logic host_cmd_valid = 1'b0, host_cmd_ready, host_cmd_op = 1'b0;
  logic [5:0] host_cmd_off = '0;
  logic [6:0] host_cmd_len = '0;
  logic host_rd_valid, host_rd_ready, host_rd_last, host_err;
  logic [7:0] host_rd_data;

  int n_checks = 0;
  int n_errors = 0;
  bit mon_stall = 1'b0, host_stall = 1'b0;
  bit mon_hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  diag_status_mem u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel_spi(host_sel_spi), .mon_use_spi(mon_use_spi),
    .sw_wr_en(sw_wr_en), .sw_wr_addr(sw_wr_addr), .sw_wr_data(sw_wr_data),
    .mon_cmd_valid(mon_cmd_valid), .mon_cmd_ready(mon_cmd_ready), .mon_cmd_op(mon_cmd_op),
    .mon_cmd_off(mon_cmd_off), .mon_cmd_len(mon_cmd_len),
    .mon_rd_valid(mon_rd_valid), .mon_rd_ready(mon_rd_ready), .mon_rd_data(mon_rd_data),
    .mon_rd_last(mon_rd_last), .mon_err(mon_err),
    .host_cmd_valid(host_cmd_valid), .host_cmd_ready(host_cmd_ready), .host_cmd_op(host_cmd_op),
    .host_cmd_off(host_cmd_off), .host_cmd_len(host_cmd_len),
    .host_rd_valid(host_rd_valid), .host_rd_ready(host_rd_ready), .host_rd_data(host_rd_data),
    .host_rd_last(host_rd_last), .host_err(host_err)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_mem [64];
  logic [7:0] m_old [64];
  logic [7:0] m_mq [$];
  logic [7:0] m_hq [$];
  bit m_mon_busy = 0, m_host_busy = 0, m_mon_err = 0, m_host_err = 0;
  bit m_pin = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) m_mem[k] = 8'h00;
      m_mq.delete(); m_hq.delete();
      m_mon_busy = 0; m_host_busy = 0; m_mon_err = 0; m_host_err = 0;
      m_pin = host_sel_spi;
    end else begin
      bit mb, hb, bad;
      int off, len;
      m_old = m_mem;
      mb = m_mon_busy; hb = m_host_busy;
      m_mon_err = 0; m_host_err = 0;
      if (mb) begin
        if (mon_rd_ready) begin
          void'(m_mq.pop_front());
          if (m_mq.size() == 0) m_mon_busy = 0;
        end
      end else if (mon_cmd_valid) begin
        off = int'(mon_cmd_off); len = int'(mon_cmd_len);
        bad = (len == 0) || (off + len > 64);
        if (bad) m_mon_err = 1;
        else if (!mon_cmd_op) begin
          for (int k = 0; k < len; k++) m_mq.push_back(m_old[off+k]);
          m_mon_busy = 1;
        end else begin
          for (int k = 0; k < len; k++) m_mem[off+k] = 8'h00;
        end
      end
      if (hb) begin
        if (host_rd_ready) begin
          void'(m_hq.pop_front());
          if (m_hq.size() == 0) m_host_busy = 0;
        end
      end else if (host_cmd_valid) begin
        off = int'(host_cmd_off); len = int'(host_cmd_len);
        bad = (len == 0) || (off + len > 64) || host_cmd_op;
        if (bad) m_host_err = 1;
        else begin
          for (int k = 0; k < len; k++) m_hq.push_back(m_old[off+k]);
          m_host_busy = 1;
        end
      end
      if (sw_wr_en) m_mem[sw_wr_addr] = sw_wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(mon_cmd_ready == !m_mon_busy, "R10 mon_cmd_ready", int'(mon_cmd_ready), int'(!m_mon_busy));
      chk(mon_rd_valid == m_mon_busy, "R3 mon_rd_valid", int'(mon_rd_valid), int'(m_mon_busy));
      if (m_mon_busy && m_mq.size() > 0) begin
        chk(mon_rd_data == m_mq[0], "R3,R4 mon_rd_data", int'(mon_rd_data), int'(m_mq[0]));
        chk(mon_rd_last == (m_mq.size() == 1), "R3 mon_rd_last", int'(mon_rd_last), int'(m_mq.size() == 1));
      end
      chk(mon_err == m_mon_err, "R7 mon_err", int'(mon_err), int'(m_mon_err));
      chk(host_cmd_ready == !m_host_busy, "R10 host_cmd_ready", int'(host_cmd_ready), int'(!m_host_busy));
      chk(host_rd_valid == m_host_busy, "R8 host_rd_valid", int'(host_rd_valid), int'(m_host_busy));
      if (m_host_busy && m_hq.size() > 0) begin
        chk(host_rd_data == m_hq[0], "R8 host_rd_data", int'(host_rd_data), int'(m_hq[0]));
        chk(host_rd_last == (m_hq.size() == 1), "R8 host_rd_last", int'(host_rd_last), int'(m_hq.size() == 1));
      end
      chk(host_err == m_host_err, "R8 host_err", int'(host_err), int'(m_host_err));
      chk(mon_use_spi == !m_pin, "R9 mon_use_spi", int'(mon_use_spi), int'(!m_pin));
    end
  end

  // Read-ready drivers.
  always @(negedge clk) begin
    mon_rd_ready  <= mon_hold ? 1'b0 : (mon_stall ? 1'($urandom_range(0, 1)) : 1'b1);
    host_rd_ready <= host_stall ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // Drive any mix of monitor command, host command and software write on one edge.
  task automatic issue(input bit mv, input bit mop, input int moff, input int mlen,
                       input bit hv, input bit hop, input int hoff, input int hlen,
                       input bit sv, input int sa, input int sd);
    @(negedge clk);
    while ((mv && m_mon_busy) || (hv && m_host_busy)) @(negedge clk);
    mon_cmd_valid = mv; mon_cmd_op = mop; mon_cmd_off = 6'(moff); mon_cmd_len = 7'(mlen);
    host_cmd_valid = hv; host_cmd_op = hop; host_cmd_off = 6'(hoff); host_cmd_len = 7'(hlen);
    sw_wr_en = sv; sw_wr_addr = 6'(sa); sw_wr_data = 8'(sd);
    @(negedge clk);
    mon_cmd_valid = 0; host_cmd_valid = 0; sw_wr_en = 0;
  endtask

  task automatic mon_cmd(input bit op, input int off, input int len);
    issue(1, op, off, len, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic host_cmd(input bit op, input int off, input int len);
    issue(0, 0, 0, 0, 1, op, off, len, 0, 0, 0);
  endtask

  task automatic sw_write(input int a, input int d);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic drain();
    @(negedge clk);
    while (m_mon_busy || m_host_busy) @(negedge clk);
  endtask

  // Watchdog.
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    mon_rd_ready = 1'b1; host_rd_ready = 1'b1;
    // Pin toggles during reset; the final value before release counts (R9).
    repeat (3) @(negedge clk);
    host_sel_spi = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mon_cmd_ready == 1'b1, "R1 mon_cmd_ready", int'(mon_cmd_ready), 1);
    chk(host_cmd_ready == 1'b1, "R1 host_cmd_ready", int'(host_cmd_ready), 1);
    chk(mon_rd_valid == 1'b0 && host_rd_valid == 1'b0, "R1 rd_valid", int'(mon_rd_valid | host_rd_valid), 0);
    chk(mon_err == 1'b0 && host_err == 1'b0, "R1 err", int'(mon_err | host_err), 0);
    chk(mon_use_spi == 1'b0, "R9 latched select", int'(mon_use_spi), 0);
    mon_cmd(0, 0, 64);                  // R1 all zero
    drain();
    host_sel_spi = 1'b0;                // R9 pin ignored after reset

    // R2 fill pattern and read back in several shapes
    for (int i = 0; i < 64; i++) sw_write(i, (i * 7 + 3) & 8'hFF);
    mon_cmd(0, 0, 1);
    mon_cmd(0, 5, 10);
    mon_cmd(0, 60, 4);
    mon_stall = 1; mon_cmd(0, 0, 64); drain(); mon_stall = 0;

    // R8 host read and refused host clear
    host_cmd(0, 10, 3);
    host_cmd(1, 0, 8);
    host_cmd(0, 0, 8);
    drain();

    // R5 monitor clear, then read across the edge of the cleared span
    mon_cmd(1, 8, 4);
    mon_cmd(0, 6, 8);
    drain();

    // R6 software write into a range being cleared on the same edge
    issue(1, 1, 20, 5, 0, 0, 0, 0, 1, 22, 8'hA5);
    mon_cmd(0, 18, 9);
    drain();

    // R7 rejected ranges and zero length
    mon_cmd(0, 60, 5);
    mon_cmd(1, 63, 2);
    mon_cmd(1, 0, 0);
    host_cmd(0, 40, 30);
    mon_cmd(0, 0, 64);
    drain();
    mon_cmd(0, 63, 1);
    drain();

    // R4 snapshot: stall the reply while software rewrites the bytes
    mon_hold = 1;
    mon_cmd(0, 30, 4);
    for (int i = 30; i < 34; i++) sw_write(i, 8'hF0 + i);
    mon_hold = 0;
    drain();
    mon_cmd(0, 30, 4);
    drain();

    // R4 host read accepted on the same edge as an overlapping monitor clear
    issue(1, 1, 40, 8, 1, 0, 38, 12, 0, 0, 0);
    drain();
    host_cmd(0, 38, 12);
    drain();

    // Randomized mix
    mon_stall = 1; host_stall = 1;
    for (int n = 0; n < 300; n++) begin
      issue($urandom_range(0, 1), 1'($urandom_range(0, 1)), $urandom_range(0, 63), $urandom_range(0, 66),
            $urandom_range(0, 1), 1'($urandom_range(0, 3) == 0), $urandom_range(0, 63), $urandom_range(0, 66),
            $urandom_range(0, 1), $urandom_range(0, 63), $urandom_range(0, 255));
    end
    mon_stall = 0; host_stall = 0;
    drain();
    mon_cmd(0, 0, 64);
    host_cmd(0, 0, 64);
    drain();
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule